// File: doc/BRIEF.md
# ECC error monitor register unit

This block gathers diagnostic events from up to five memory ECC controllers and presents them to software through a bank of 32-bit registers. Each controller reports a corrected single-bit error, a double-bit error found on a read, or a double-bit error found during the read-modify-write of a partial-word store. The block records each event in a sticky flag for that monitor. When context capture is enabled for that monitor, it also records the failing address, data word and check code. A single level-sensitive interrupt line is raised through two layers of enables: a master switch with per-type enables shared by all monitors, and per-type enables local to each monitor.

The register port is a plain valid/write/size/address/data bus with a one-cycle registered read return. Each access is classified in the cycle it is presented. The enumerated access classes are IDLE (no request), READ (aligned word read), WRITE (aligned word write) and DROP (any request that is not an aligned full word). The classification has no history, and every class returns to IDLE as soon as the request is withdrawn. Only READ loads the read register, only WRITE updates state, and IDLE and DROP load zero into the read register.

Top module: `ecc_mon_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `reg_rdata` is zero.
- R2: The register at offset 0x00 holds four shared enable bits: bit 0 master, bit 1 single-error, bit 2 read double-error, bit 3 byte-write double-error. All other bits read zero.
- R3: Monitor x (1..NUM_MON) has its configuration at 0x20·x, status at +0x04, address at +0x08, low data at +0x0C, high data at +0x10 and code at +0x14. Configuration bit 2 enables single-error, bit 3 double-error, bit 4 byte-write double-error and bit 5 capture; other bits read zero. Any offset outside this map (including absent monitors and +0x18/+0x1C) reads zero.
- R4: An event with `evt_valid` set and kind 2'b00 (single), 2'b01 (read double) or 2'b10 (byte-write double) sets status bit 0, 1 or 2 respectively; kind 2'b11 has no effect.
- R5: A status flag is cleared by writing 0 to its bit; writing 1 leaves it unchanged. If an event sets a flag in the same cycle that software clears it, the flag ends set.
- R6: With capture enabled, a single or read-double event stores its address, data and code, overwriting any earlier capture; a byte-write double event stores nothing.
- R7: With capture disabled, the capture registers keep their values when events arrive.
- R8: For a 64-bit monitor (set in WIDE_MASK), the high data register holds data bits 63:32. For a 32-bit monitor, the low data register holds the full word and the high data register reads zero.
- R9: `irq` is high exactly when the master bit is set and some monitor has a set flag whose type is enabled either in the shared register or in that monitor's configuration.
- R10: Accesses with `reg_size` other than 2'b10 (word), or with `reg_addr[1:0]` non-zero, change no state and return zero.
- R11: `reg_rdata` is registered. It shows the value a READ addressed at the clock edge that accepted it, taken before any update at that same edge, and it is zero after any cycle without a READ.
- R12: Writes to the capture registers (address, data, code) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| reg_addr | input | REG_AW | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_valid | input | NUM_MON | Per-monitor event strobe |
| evt_kind | input | 2·NUM_MON | Per-monitor event kind |
| evt_addr | input | 32·NUM_MON | Per-monitor failing address |
| evt_data | input | 64·NUM_MON | Per-monitor failing data word |
| evt_code | input | CODE_W·NUM_MON | Per-monitor failing check code |
| irq | output | 1 | Interrupt request |

## Verification
A flag that is lost, wrongly set or not sticky appears on `irq` in the cycle after the event whenever a matching enable is on, and at the latest on the next status read. A bad capture decision shows as a wrong address, data or code value on the read return one cycle after the read is presented. A misclassified access shows either as a non-zero return for a dropped access or as an enable that has silently changed. The bench keeps a behavioural model of all registers and compares `irq` and `reg_rdata` with it on every clock, so a divergence is reported within one cycle of becoming visible.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;

    localparam int REG_W  = 32;
    localparam int EVT_DW = 64;
    localparam int HALF_W = EVT_DW / 2;

    typedef enum logic [1:0] {
        EV_SINGLE = 2'b00,
        EV_DOUBLE = 2'b01,
        EV_BYTEWR = 2'b10,
        EV_NONE   = 2'b11
    } ev_kind_e;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_DROP
    } acc_e;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam logic [2:0] SUB_CFG  = 3'd0;
    localparam logic [2:0] SUB_STAT = 3'd1;
    localparam logic [2:0] SUB_ADDR = 3'd2;
    localparam logic [2:0] SUB_DLO  = 3'd3;
    localparam logic [2:0] SUB_DHI  = 3'd4;
    localparam logic [2:0] SUB_CODE = 3'd5;

    typedef struct packed {
        logic latch;
        logic bw;
        logic de;
        logic se;
    } mon_cfg_t;

    typedef struct packed {
        logic bw;
        logic de;
        logic se;
        logic master;
    } gen_cfg_t;

endpackage

// File: rtl/ecc_mon_slot.sv
module ecc_mon_slot
    import ecc_mon_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter bit WIDE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [REG_W-1:0]  evt_addr,
    input  logic [EVT_DW-1:0] evt_data,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_wdata,
    input  logic              stat_we,
    input  logic [2:0]        stat_wdata,
    output mon_cfg_t          cfg_q,
    output logic [2:0]        flags_q,
    output logic [REG_W-1:0]  cap_addr,
    output logic [REG_W-1:0]  cap_dlo,
    output logic [REG_W-1:0]  cap_dhi,
    output logic [CODE_W-1:0] cap_code
);

    ev_kind_e   kind;
    logic [2:0] hw_set;
    logic [2:0] flags_d;
    logic       cap_en;

    assign kind = ev_kind_e'(evt_kind);

    always_comb begin
        hw_set = 3'b000;
        if (evt_valid) begin
            unique case (kind)
                EV_SINGLE: hw_set = 3'b001;
                EV_DOUBLE: hw_set = 3'b010;
                EV_BYTEWR: hw_set = 3'b100;
                EV_NONE:   hw_set = 3'b000;
            endcase
        end
    end

    // software clear first, hardware set on top: the set wins a same-cycle race
    always_comb begin
        flags_d = stat_we ? (flags_q & stat_wdata) : flags_q;
        flags_d = flags_d | hw_set;
    end

    assign cap_en = cfg_q.latch && (hw_set[0] || hw_set[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            flags_q  <= '0;
            cap_addr <= '0;
            cap_dlo  <= '0;
            cap_code <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q <= mon_cfg_t'(cfg_wdata);
            end
            flags_q <= flags_d;
            if (cap_en) begin
                cap_addr <= evt_addr;
                cap_dlo  <= evt_data[HALF_W-1:0];
                cap_code <= evt_code;
            end
        end
    end

    generate
        if (WIDE) begin : g_wide
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cap_dhi <= '0;
                end else if (cap_en) begin
                    cap_dhi <= evt_data[EVT_DW-1:HALF_W];
                end
            end
        end else begin : g_narrow
            logic unused_hi;
            assign unused_hi = ^evt_data[EVT_DW-1:HALF_W];
            assign cap_dhi   = '0;
        end
    endgenerate

    // R4: a single-error event is always recorded
    a_r4_single_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_kind == 2'b00 |=> flags_q[0]);

    // R5: a flag stays set unless software writes 0 to it
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[0] && !(stat_we && !stat_wdata[0]) |=> flags_q[0]);

    // R5: a clear with no competing event empties the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we && !stat_wdata[0] && !(evt_valid && evt_kind == 2'b00) |=> !flags_q[0]);

    // R6: a latched read error captures the event address
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && cfg_q.latch && !evt_kind[1] |=> cap_addr == $past(evt_addr));

    // R7: without capture enabled the address holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.latch |=> $stable(cap_addr));

endmodule

// File: rtl/ecc_mon_irq.sv
module ecc_mon_irq
    import ecc_mon_pkg::*;
#(
    parameter int NUM_MON = 5
) (
    input  gen_cfg_t               gen_q,
    input  logic [3*NUM_MON-1:0]   flags_flat,
    input  logic [3*NUM_MON-1:0]   types_flat,
    output logic                   irq
);

    logic [2:0] gen_types;
    logic       hit;

    assign gen_types = {gen_q.bw, gen_q.de, gen_q.se};

    always_comb begin
        hit = 1'b0;
        for (int m = 0; m < NUM_MON; m++) begin
            hit = hit | (|(flags_flat[3*m +: 3] & (types_flat[3*m +: 3] | gen_types)));
        end
    end

    assign irq = gen_q.master && hit;

endmodule

// File: rtl/ecc_mon_top.sv
module ecc_mon_top
    import ecc_mon_pkg::*;
#(
    parameter int                 NUM_MON   = 5,
    parameter int                 CODE_W    = 8,
    parameter int                 REG_AW    = 8,
    parameter logic [NUM_MON-1:0] WIDE_MASK = 5'b00001
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_valid,
    input  logic                      reg_write,
    input  logic [1:0]                reg_size,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    input  logic [NUM_MON-1:0]        evt_valid,
    input  logic [2*NUM_MON-1:0]      evt_kind,
    input  logic [REG_W*NUM_MON-1:0]  evt_addr,
    input  logic [EVT_DW*NUM_MON-1:0] evt_data,
    input  logic [CODE_W*NUM_MON-1:0] evt_code,
    output logic                      irq
);

    localparam int MON_IDX_W = REG_AW - 5;

    acc_e                 acc;
    logic [MON_IDX_W-1:0] mon_sel;
    logic [2:0]           sub;
    gen_cfg_t             gen_q;
    logic [REG_W-1:0]     rd_val;
    logic [REG_W-1:0]     rdata_q;

    mon_cfg_t             cfg_q    [NUM_MON];
    logic [2:0]           flags_q  [NUM_MON];
    logic [REG_W-1:0]     cap_addr [NUM_MON];
    logic [REG_W-1:0]     cap_dlo  [NUM_MON];
    logic [REG_W-1:0]     cap_dhi  [NUM_MON];
    logic [CODE_W-1:0]    cap_code [NUM_MON];
    logic [3*NUM_MON-1:0] flags_flat;
    logic [3*NUM_MON-1:0] types_flat;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[REG_W-1:6];

    assign mon_sel = reg_addr[REG_AW-1:5];
    assign sub     = reg_addr[4:2];

    // per-cycle access classification
    always_comb begin
        if (!reg_valid) begin
            acc = ACC_IDLE;
        end else if (reg_size != SIZE_WORD || reg_addr[1:0] != 2'b00) begin
            acc = ACC_DROP;
        end else if (reg_write) begin
            acc = ACC_WRITE;
        end else begin
            acc = ACC_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else if (acc == ACC_WRITE && mon_sel == '0 && sub == SUB_CFG) begin
            gen_q <= gen_cfg_t'(reg_wdata[3:0]);
        end
    end

    generate
        for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
            logic cfg_we;
            logic stat_we;
            assign cfg_we  = (acc == ACC_WRITE) && (mon_sel == MON_IDX_W'(m + 1)) && (sub == SUB_CFG);
            assign stat_we = (acc == ACC_WRITE) && (mon_sel == MON_IDX_W'(m + 1)) && (sub == SUB_STAT);

            ecc_mon_slot #(
                .CODE_W (CODE_W),
                .WIDE   (WIDE_MASK[m])
            ) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .evt_valid  (evt_valid[m]),
                .evt_kind   (evt_kind[2*m +: 2]),
                .evt_addr   (evt_addr[REG_W*m +: REG_W]),
                .evt_data   (evt_data[EVT_DW*m +: EVT_DW]),
                .evt_code   (evt_code[CODE_W*m +: CODE_W]),
                .cfg_we     (cfg_we),
                .cfg_wdata  (reg_wdata[5:2]),
                .stat_we    (stat_we),
                .stat_wdata (reg_wdata[2:0]),
                .cfg_q      (cfg_q[m]),
                .flags_q    (flags_q[m]),
                .cap_addr   (cap_addr[m]),
                .cap_dlo    (cap_dlo[m]),
                .cap_dhi    (cap_dhi[m]),
                .cap_code   (cap_code[m])
            );

            assign flags_flat[3*m +: 3] = flags_q[m];
            assign types_flat[3*m +: 3] = {cfg_q[m].bw, cfg_q[m].de, cfg_q[m].se};
        end
    endgenerate

    ecc_mon_irq #(
        .NUM_MON (NUM_MON)
    ) u_irq (
        .gen_q      (gen_q),
        .flags_flat (flags_flat),
        .types_flat (types_flat),
        .irq        (irq)
    );

    // read multiplexer
    always_comb begin
        rd_val = '0;
        if (mon_sel == '0 && sub == SUB_CFG) begin
            rd_val = REG_W'(gen_q);
        end
        for (int m = 0; m < NUM_MON; m++) begin
            if (mon_sel == MON_IDX_W'(m + 1)) begin
                unique case (sub)
                    SUB_CFG:  rd_val = REG_W'({cfg_q[m], 2'b00});
                    SUB_STAT: rd_val = REG_W'(flags_q[m]);
                    SUB_ADDR: rd_val = cap_addr[m];
                    SUB_DLO:  rd_val = cap_dlo[m];
                    SUB_DHI:  rd_val = cap_dhi[m];
                    SUB_CODE: rd_val = REG_W'(cap_code[m]);
                    default:  rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (acc)
                ACC_READ:  rdata_q <= rd_val;
                ACC_IDLE:  rdata_q <= '0;
                ACC_WRITE: rdata_q <= '0;
                ACC_DROP:  rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;

    // R9: the line never rises without the master enable
    a_r9_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gen_q.master);

    // R10: a non-word read returns zero
    a_r10_drop_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && reg_size != SIZE_WORD |=> reg_rdata == '0);

    // R10: a non-word write leaves the shared enables unchanged
    a_r10_drop_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_write && reg_size != SIZE_WORD |=> $stable(gen_q));

    // R11: the read return is zero after a cycle with no request
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_valid |=> reg_rdata == '0);

endmodule

// File: tb/ecc_mon_top_tb.sv
module ecc_mon_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NMON       = 5;
    localparam int CW         = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_valid = 1'b0;
    logic              reg_write = 1'b0;
    logic [1:0]        reg_size = 2'b10;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NMON-1:0]   evt_valid = '0;
    logic [2*NMON-1:0] evt_kind = '0;
    logic [32*NMON-1:0] evt_addr = '0;
    logic [64*NMON-1:0] evt_data = '0;
    logic [CW*NMON-1:0] evt_code = '0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_mon_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_size  (reg_size),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_addr  (evt_addr),
        .evt_data  (evt_data),
        .evt_code  (evt_code),
        .irq       (irq)
    );

    // behavioural reference model
    logic [3:0]  m_gen;
    logic [3:0]  m_cfg  [NMON];
    logic [2:0]  m_fl   [NMON];
    logic [31:0] m_addr [NMON];
    logic [63:0] m_data [NMON];
    logic [7:0]  m_code [NMON];
    logic [31:0] m_rdata;

    function automatic logic [31:0] mread(input logic [7:0] a);
        int idx;
        int sub;
        idx = int'(a[7:5]);
        sub = int'(a[4:2]);
        if (a[1:0] != 2'b00) return 32'h0;
        if (idx == 0) return (sub == 0) ? {28'h0, m_gen} : 32'h0;
        if (idx > NMON) return 32'h0;
        case (sub)
            0: return {26'h0, m_cfg[idx-1], 2'b00};
            1: return {29'h0, m_fl[idx-1]};
            2: return m_addr[idx-1];
            3: return m_data[idx-1][31:0];
            4: return (idx == 1) ? m_data[idx-1][63:32] : 32'h0;
            5: return {24'h0, m_code[idx-1]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic model_irq();
        logic any;
        any = 1'b0;
        for (int m = 0; m < NMON; m++) begin
            for (int b = 0; b < 3; b++) begin
                if (m_fl[m][b] && (m_cfg[m][b] || m_gen[b+1])) any = 1'b1;
            end
        end
        return m_gen[0] && any;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gen = 4'h0;
            m_rdata = 32'h0;
            for (int m = 0; m < NMON; m++) begin
                m_cfg[m] = 4'h0; m_fl[m] = 3'h0; m_addr[m] = 32'h0;
                m_data[m] = 64'h0; m_code[m] = 8'h0;
            end
        end else begin
            logic ok;
            int idx;
            int sub;
            ok  = reg_valid && reg_size == 2'b10 && reg_addr[1:0] == 2'b00;
            idx = int'(reg_addr[7:5]);
            sub = int'(reg_addr[4:2]);
            m_rdata = (ok && !reg_write) ? mread(reg_addr) : 32'h0;
            if (ok && reg_write) begin
                if (idx == 0 && sub == 0) m_gen = reg_wdata[3:0];
                else if (idx >= 1 && idx <= NMON) begin
                    if (sub == 0) m_cfg[idx-1] = reg_wdata[5:2];
                    if (sub == 1) m_fl[idx-1] = m_fl[idx-1] & reg_wdata[2:0];
                end
            end
            for (int m = 0; m < NMON; m++) begin
                if (evt_valid[m]) begin
                    case (evt_kind[2*m +: 2])
                        2'b00, 2'b01: begin
                            m_fl[m] = m_fl[m] | ((evt_kind[2*m +: 2] == 2'b00) ? 3'b001 : 3'b010);
                            if (m_cfg[m][3]) begin
                                m_addr[m] = evt_addr[32*m +: 32];
                                m_data[m] = evt_data[64*m +: 64];
                                m_code[m] = evt_code[CW*m +: CW];
                            end
                        end
                        2'b10: m_fl[m] = m_fl[m] | 3'b100;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(irq == model_irq(), "R9 irq vs model", {31'h0, irq}, {31'h0, model_irq()});
            check(reg_rdata == m_rdata, "R11 rdata vs model", reg_rdata, m_rdata);
        end
    end

    task automatic clear_in();
        reg_valid = 1'b0; reg_write = 1'b0; reg_size = 2'b10;
        reg_addr = '0; reg_wdata = '0; evt_valid = '0;
    endtask

    task automatic wr_sz(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        clear_in();
        reg_valid = 1'b1; reg_write = 1'b1; reg_size = sz; reg_addr = a; reg_wdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_sz(a, d, 2'b10);
    endtask

    task automatic rd_sz(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
        @(negedge clk);
        clear_in();
        reg_valid = 1'b1; reg_size = sz; reg_addr = a;
        @(negedge clk);
        clear_in();
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_sz(a, 2'b10, exp, tag);
    endtask

    task automatic drive_ev(input int m, input logic [1:0] k, input logic [31:0] a,
                            input logic [63:0] d, input logic [7:0] c);
        evt_valid[m] = 1'b1;
        evt_kind[2*m +: 2] = k;
        evt_addr[32*m +: 32] = a;
        evt_data[64*m +: 64] = d;
        evt_code[CW*m +: CW] = c;
    endtask

    task automatic ev(input int m, input logic [1:0] k, input logic [31:0] a,
                      input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        clear_in();
        drive_ev(m, k, a, d, c);
    endtask

    task automatic irq_is(input logic exp, input string tag);
        @(negedge clk);
        clear_in();
        check(irq == exp, tag, {31'h0, irq}, {31'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        irq_is(1'b0, "R1 irq after reset");
        rd(8'h00, 32'h0, "R1 shared enables reset");
        rd(8'h24, 32'h0, "R1 status reset");
        rd(8'h34, 32'h0, "R1 code reset");

        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_000F, "R2 shared enables width");
        wr(8'h00, 32'h0);

        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0000_003C, "R3 config bits");
        rd(8'h38, 32'h0, "R3 unused slot offset");
        rd(8'h04, 32'h0, "R3 unused low offset");
        rd(8'hC0, 32'h0, "R3 absent monitor");

        ev(0, 2'b00, 32'h0000_1000, 64'hAAAA_BBBB_CCCC_DDDD, 8'h5A);
        rd(8'h24, 32'h1, "R4 single sets bit0");
        rd(8'h28, 32'h0000_1000, "R6 captured address");
        rd(8'h2C, 32'hCCCC_DDDD, "R6 captured low data");
        rd(8'h30, 32'hAAAA_BBBB, "R8 wide high data");
        rd(8'h34, 32'h0000_005A, "R6 captured code");
        irq_is(1'b0, "R9 master off");
        wr(8'h00, 32'h1);
        irq_is(1'b1, "R9 monitor enable path");

        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, 32'h1, "R5 write one keeps flag");
        wr(8'h24, 32'h0);
        rd(8'h24, 32'h0, "R5 write zero clears");
        irq_is(1'b0, "R9 no flags");

        @(negedge clk);
        clear_in();
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h0;
        drive_ev(0, 2'b01, 32'h0000_1008, 64'h0123_4567_89AB_CDEF, 8'h33);
        rd(8'h24, 32'h2, "R5 set wins over clear");
        rd(8'h28, 32'h0000_1008, "R6 most recent capture");
        irq_is(1'b1, "R9 double enabled in monitor");
        wr(8'h24, 32'h0);

        ev(1, 2'b00, 32'h0000_2000, 64'h5555_6666_7777_8888, 8'h11);
        rd(8'h44, 32'h1, "R4 second monitor single");
        rd(8'h48, 32'h0, "R7 no capture address");
        rd(8'h54, 32'h0, "R7 no capture code");
        irq_is(1'b0, "R9 type not enabled");
        wr(8'h00, 32'h3);
        irq_is(1'b1, "R9 shared type path");

        wr(8'h40, 32'h20);
        ev(1, 2'b01, 32'h0000_2004, 64'h1111_2222_3333_4444, 8'h22);
        rd(8'h4C, 32'h3333_4444, "R8 narrow low word");
        rd(8'h50, 32'h0, "R8 narrow high reads zero");
        rd(8'h48, 32'h0000_2004, "R6 capture after enable");

        ev(1, 2'b10, 32'h0000_3000, 64'h9999_9999_9999_9999, 8'h44);
        rd(8'h44, 32'h7, "R4 byte-write sets bit2");
        rd(8'h48, 32'h0000_2004, "R6 byte-write not captured");

        ev(2, 2'b11, 32'h0000_4000, 64'h1, 8'h1);
        rd(8'h64, 32'h0, "R4 kind 3 ignored");

        wr_sz(8'h00, 32'h0, 2'b00);
        rd(8'h00, 32'h3, "R10 byte write ignored");
        rd_sz(8'h00, 2'b01, 32'h0, "R10 halfword read zero");
        rd(8'h01, 32'h0, "R10 misaligned read zero");
        wr(8'h02, 32'h0);
        rd(8'h00, 32'h3, "R10 misaligned write ignored");

        wr(8'h48, 32'h0000_DEAD);
        rd(8'h48, 32'h0000_2004, "R12 address read-only");
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, 32'h0, "R12 high data read-only");

        @(negedge clk);
        clear_in();
        check(reg_rdata == 32'h0, "R11 idle returns zero", reg_rdata, 32'h0);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule